// File: doc/BRIEF.md
# Byte Program-Verify Controller

The controller writes a stream of bytes into a flash array that only clears bits when a timed program pulse is applied. Each request carries an address and a data byte. For every byte it writes the setup-program command (40h) to the target address, then writes the data byte to the same address. It holds the program pulse for a fixed number of cycles and waits a fixed recovery interval. It then issues a verify command, strobes a read and compares the returned byte with the intended one.

A matching byte completes the request. The controller reports how many pulses the byte took and accepts the next request. A mismatch repeats the whole attempt on the same byte. When the last allowed pulse still fails to verify, the device is sent the reset command twice so that it returns to read mode. The controller then stops with an error flag raised, and clearing that flag lets it continue.

Top module: `flash_pgm_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is high and `bus_we_o`, `bus_re_o`, `pulse_o`, `done_o`, `fail_o` and `last_pulses_o` are all zero.
- R2: Each attempt writes 40h to the request address, then in the next cycle writes the request data byte to that same address, and the pulse starts in the cycle after.
- R3: `pulse_o` stays high for exactly PULSE_CYC consecutive cycles per attempt (default 10), with no bus strobe during it.
- R4: After the pulse, exactly RECOV_CYC cycles (default 6) pass with no strobe. Then one write of the verify command C0h is made, followed by one read strobe. `bus_rdata_i` is compared in the cycle after the read strobe.
- R5: A matching read-back raises `done_o` for one cycle and sets `last_pulses_o` to the number of pulses used. In that same cycle `req_ready_o` is high again, and no further bus writes are made for that byte.
- R6: A mismatch on an attempt numbered below MAX_PULSES (default 25) repeats the full R2–R4 sequence for the same address and data. The number of setup writes therefore equals the number of pulses.
- R7: A mismatch on attempt MAX_PULSES is followed by exactly two consecutive writes of FFh. After them `fail_o` is high and `last_pulses_o` equals MAX_PULSES. While `fail_o` is high, `req_valid_i` is ignored: no strobes are made and `req_ready_o` stays low.
- R8: `fail_o` stays high until `err_clr_i` is sampled high. In the cycle after that, `fail_o` is low and `req_ready_o` is high.
- R9: `req_ready_o` is low from acceptance until completion, so a request held valid during an operation does not start a second one.
- R10: `bus_we_o` and `bus_re_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and accepting |
| req_addr_i | input | ADDR_W | Target byte address |
| req_data_i | input | 8 | Byte to program |
| bus_we_o | output | 1 | Device write strobe |
| bus_re_o | output | 1 | Device read strobe |
| bus_addr_o | output | ADDR_W | Device address |
| bus_wdata_o | output | 8 | Command or data byte for a write |
| bus_rdata_i | input | 8 | Read-back byte, valid the cycle after `bus_re_o` |
| pulse_o | output | 1 | Program pulse enable |
| done_o | output | 1 | Byte verified (one cycle) |
| fail_o | output | 1 | Pulse limit exhausted, held until cleared |
| err_clr_i | input | 1 | Clears the failure state |
| last_pulses_o | output | $clog2(MAX_PULSES+1) | Pulses used by the last finished byte |

## Verification
Two events meet in one compare cycle: a successful read-back and reaching the pulse limit. The bench provokes this with a device model that verifies a byte only after a chosen number of pulses. It sets that number to exactly MAX_PULSES, where the byte must complete with `done_o`, and to MAX_PULSES+1, where the same compare cycle must take the reset-twice path and raise `fail_o`. It judges both cases from the count of setup writes, the FFh writes seen on the bus and `last_pulses_o`.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_LOAD, ST_PULSE, ST_RECOV,
    ST_VCMD, ST_READ, ST_CMP, ST_RST1, ST_RST2, ST_HALT
  } pgm_state_e;

  localparam logic [7:0] CMD_SETUP_PGM = 8'h40;
  localparam logic [7:0] CMD_VERIFY    = 8'hC0;
  localparam logic [7:0] CMD_RESET     = 8'hFF;
endpackage

// File: rtl/pgm_interval_timer.sv
module pgm_interval_timer #(
  parameter int TMR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pgm_attempt_ctr.sv
module pgm_attempt_ctr #(
  parameter int MAX_PULSES = 25,
  parameter int CW         = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          at_max_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (inc_i && !at_max_o) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == CW'(MAX_PULSES));
endmodule

// File: rtl/pgm_bus_encode.sv
module pgm_bus_encode
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  pgm_state_e        state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              we_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              pulse_o
);
  always_comb begin
    we_o    = 1'b0;
    re_o    = 1'b0;
    wdata_o = 8'h00;
    pulse_o = 1'b0;
    addr_o  = addr_i;
    unique case (state_i)
      ST_SETUP: begin we_o = 1'b1; wdata_o = CMD_SETUP_PGM; end
      ST_LOAD:  begin we_o = 1'b1; wdata_o = data_i;        end
      ST_PULSE: pulse_o = 1'b1;
      ST_VCMD:  begin we_o = 1'b1; wdata_o = CMD_VERIFY;    end
      ST_READ:  re_o = 1'b1;
      ST_RST1,
      ST_RST2:  begin we_o = 1'b1; wdata_o = CMD_RESET;     end
      default:  ;
    endcase
  end
endmodule

// File: rtl/flash_pgm_ctrl.sv
module flash_pgm_ctrl
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PULSE_CYC  = 10,
  parameter int RECOV_CYC  = 6,
  parameter int MAX_PULSES = 25,
  localparam int CW        = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  output logic              bus_we_o,
  output logic              bus_re_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic [7:0]        bus_rdata_i,
  output logic              pulse_o,
  output logic              done_o,
  output logic              fail_o,
  input  logic              err_clr_i,
  output logic [CW-1:0]     last_pulses_o
);
  localparam int TMR_MAX = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  pgm_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [CW-1:0]     last_q, att_cnt;
  logic              done_q, fail_q;
  logic              accept, tmr_zero, tmr_load, at_max, rd_match, cmp_end;
  logic [TMR_W-1:0]  tmr_val;

  assign accept   = (state_q == ST_IDLE) && req_valid_i;
  assign rd_match = (bus_rdata_i == data_q);
  assign cmp_end  = (state_q == ST_CMP) && (rd_match || at_max);
  // pulse length loaded on the data write, recovery on the last pulse cycle
  assign tmr_load = (state_q == ST_LOAD) || ((state_q == ST_PULSE) && tmr_zero);
  assign tmr_val  = (state_q == ST_LOAD) ? TMR_W'(PULSE_CYC - 1) : TMR_W'(RECOV_CYC - 1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_PULSE;
      ST_PULSE: if (tmr_zero) state_d = ST_RECOV;
      ST_RECOV: if (tmr_zero) state_d = ST_VCMD;
      ST_VCMD:  state_d = ST_READ;
      ST_READ:  state_d = ST_CMP;
      ST_CMP: begin
        if (rd_match)    state_d = ST_IDLE;
        else if (at_max) state_d = ST_RST1;
        else             state_d = ST_SETUP;
      end
      ST_RST1:  state_d = ST_RST2;
      ST_RST2:  state_d = ST_HALT;
      ST_HALT:  if (err_clr_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_CMP) && rd_match;
      if (accept) begin
        addr_q <= req_addr_i;
        data_q <= req_data_i;
      end
      if (cmp_end) last_q <= att_cnt;
      if (state_q == ST_RST2) fail_q <= 1'b1;
      else if ((state_q == ST_HALT) && err_clr_i) fail_q <= 1'b0;
    end
  end

  pgm_interval_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  pgm_attempt_ctr #(.MAX_PULSES(MAX_PULSES), .CW(CW)) u_attempts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .inc_i    (state_q == ST_LOAD),
    .cnt_o    (att_cnt),
    .at_max_o (at_max)
  );

  pgm_bus_encode #(.ADDR_W(ADDR_W)) u_bus (
    .state_i (state_q),
    .addr_i  (addr_q),
    .data_i  (data_q),
    .we_o    (bus_we_o),
    .re_o    (bus_re_o),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o),
    .pulse_o (pulse_o)
  );

  assign req_ready_o   = (state_q == ST_IDLE);
  assign done_o        = done_q;
  assign fail_o        = fail_q;
  assign last_pulses_o = last_q;
endmodule

// File: rtl/flash_pgm_chk.sv
module flash_pgm_chk
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int MAX_PULSES = 25,
  parameter int CW         = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              bus_we_o,
  input logic              bus_re_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [7:0]        bus_wdata_o,
  input logic              pulse_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              err_clr_i,
  input logic [CW-1:0]     last_pulses_o
);
  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));

  assert_pulse_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (!bus_we_o && !bus_re_o));

  assert_prog_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> ($past(bus_we_o) && $past(bus_we_o, 2) &&
                        $past(bus_wdata_o, 2) == CMD_SETUP_PGM &&
                        $past(bus_addr_o) == $past(bus_addr_o, 2)));

  assert_recov_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> (!bus_we_o && !bus_re_o));

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_fail_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  assert_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_pulses_o <= CW'(MAX_PULSES));

  assert_halt_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!req_ready_o && !bus_we_o && !bus_re_o && !pulse_o));

  assert_fail_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !err_clr_i) |=> fail_o);

  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o || bus_we_o || bus_re_o) |-> !req_ready_o);
endmodule

bind flash_pgm_ctrl flash_pgm_chk #(
  .ADDR_W(ADDR_W), .MAX_PULSES(MAX_PULSES), .CW(CW)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_ready_o   (req_ready_o),
  .bus_we_o      (bus_we_o),
  .bus_re_o      (bus_re_o),
  .bus_addr_o    (bus_addr_o),
  .bus_wdata_o   (bus_wdata_o),
  .pulse_o       (pulse_o),
  .done_o        (done_o),
  .fail_o        (fail_o),
  .err_clr_i     (err_clr_i),
  .last_pulses_o (last_pulses_o)
);

// File: tb/flash_pgm_ctrl_tb.sv
module flash_pgm_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 8;
  localparam int PW   = 10;
  localparam int RW   = 6;
  localparam int MAXP = 25;
  localparam int CW   = $clog2(MAXP + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [7:0]    req_data_i = '0;
  logic          req_ready_o;
  logic          bus_we_o, bus_re_o;
  logic [AW-1:0] bus_addr_o;
  logic [7:0]    bus_wdata_o;
  logic [7:0]    bus_rdata_i = '0;
  logic          pulse_o, done_o, fail_o;
  logic          err_clr_i = 1'b0;
  logic [CW-1:0] last_pulses_o;

  int checks = 0;
  int failures = 0;

  flash_pgm_ctrl #(.ADDR_W(AW), .PULSE_CYC(PW), .RECOV_CYC(RW), .MAX_PULSES(MAXP)) u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_data_i,
    .bus_we_o, .bus_re_o, .bus_addr_o, .bus_wdata_o, .bus_rdata_i,
    .pulse_o, .done_o, .fail_o, .err_clr_i, .last_pulses_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // device model: a byte verifies once need_r pulses have been applied
  int            dev_att = 0;
  int            op_base = 0;
  int            need_r = 1;
  logic          dev_arm = 1'b0;
  logic [AW-1:0] cur_addr = '0;
  logic [7:0]    cur_data = '0;

  always @(posedge clk_i) begin
    if (bus_we_o) begin
      if (dev_arm) begin dev_att <= dev_att + 1; dev_arm <= 1'b0; end
      else dev_arm <= (bus_wdata_o == 8'h40);
    end
    if (bus_re_o) bus_rdata_i <= ((dev_att - op_base) >= need_r) ? cur_data : ~cur_data;
  end

  // bus monitor
  int n_setup, n_ff, n_we, bad_order, bad_pw, bad_gap, pw_run, gap_run;
  bit in_gap, exp_data;
  initial begin
    n_setup = 0; n_ff = 0; n_we = 0; bad_order = 0; bad_pw = 0; bad_gap = 0;
    pw_run = 0; gap_run = 0; in_gap = 0; exp_data = 0;
  end

  always @(negedge clk_i) if (rst_ni) begin
    if (pulse_o) pw_run++;
    else if (pw_run != 0) begin
      if (pw_run != PW) bad_pw++;
      pw_run = 0; in_gap = 1; gap_run = 0;
    end
    if (in_gap && !pulse_o) begin
      if (bus_we_o || bus_re_o) begin
        if (!(bus_we_o && bus_wdata_o == 8'hC0 && gap_run == RW)) bad_gap++;
        in_gap = 0;
      end else gap_run++;
    end
    if (bus_we_o) begin
      n_we++;
      if (exp_data) begin
        if (bus_addr_o != cur_addr || bus_wdata_o != cur_data) bad_order++;
        exp_data = 0;
      end else if (bus_wdata_o == 8'h40) begin
        n_setup++; exp_data = 1;
        if (bus_addr_o != cur_addr) bad_order++;
      end else if (bus_wdata_o == 8'hFF) n_ff++;
    end else if (exp_data) begin
      bad_order++; exp_data = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic run_op(input logic [AW-1:0] a, input logic [7:0] d, input int need, input int hold);
    bit exp_fail;
    int exp_att, w0;
    exp_fail = (need > MAXP);
    exp_att  = exp_fail ? MAXP : need;
    cur_addr = a; cur_data = d; need_r = need; op_base = dev_att;
    n_setup = 0; n_ff = 0; bad_order = 0; bad_pw = 0; bad_gap = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_data_i = d;
    @(negedge clk_i);
    chk(!req_ready_o, "R9 busy after accept", req_ready_o, 0);
    for (int i = 0; i < hold; i++) @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int i = 0; i < 4000 && !(done_o || fail_o); i++) @(negedge clk_i);
    chk(done_o == !exp_fail, exp_fail ? "R7 no done" : "R5 done", done_o, !exp_fail);
    chk(fail_o == exp_fail, exp_fail ? "R7 fail" : "R5 no fail", fail_o, exp_fail);
    chk(int'(last_pulses_o) == exp_att, "R5 R7 last_pulses", last_pulses_o, exp_att);
    chk(n_setup == exp_att, "R6 attempts", n_setup, exp_att);
    chk(bad_order == 0, "R2 order", bad_order, 0);
    chk(bad_pw == 0, "R3 pulse width", bad_pw, 0);
    chk(bad_gap == 0, "R4 recovery gap", bad_gap, 0);
    chk(n_ff == (exp_fail ? 2 : 0), "R7 reset writes", n_ff, exp_fail ? 2 : 0);
    if (!exp_fail) begin
      chk(req_ready_o, "R5 ready", req_ready_o, 1);
      w0 = n_we;
      @(negedge clk_i);
      chk(!done_o, "R5 done one cycle", done_o, 0);
      repeat (3) @(negedge clk_i);
      chk(n_we == w0, "R5 no further writes", n_we - w0, 0);
    end else begin
      chk(!req_ready_o, "R7 ready low", req_ready_o, 0);
      w0 = n_we;
      req_valid_i = 1'b1;
      repeat (12) @(negedge clk_i);
      req_valid_i = 1'b0;
      chk(n_we == w0 && !pulse_o, "R7 requests ignored", n_we - w0, 0);
      chk(fail_o, "R8 fail held", fail_o, 1);
      err_clr_i = 1'b1;
      @(negedge clk_i);
      err_clr_i = 1'b0;
      chk(!fail_o, "R8 fail cleared", fail_o, 0);
      chk(req_ready_o, "R8 ready after clear", req_ready_o, 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int nd;
    void'($urandom(32'd2741));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o, "R1 ready", req_ready_o, 1);
    chk(!bus_we_o && !bus_re_o && !pulse_o, "R1 quiet bus", {bus_we_o, bus_re_o, pulse_o}, 0);
    chk(!done_o && !fail_o, "R1 flags", {done_o, fail_o}, 0);
    chk(last_pulses_o == '0, "R1 last_pulses", last_pulses_o, 0);

    run_op(8'h10, 8'h5A, 1, 0);
    run_op(8'h11, 8'h40, 3, 0);        // data equal to setup code
    run_op(8'h12, 8'hFF, 2, 6);        // R9: valid held during op
    run_op(8'h13, 8'hC0, MAXP, 0);     // verifies on the last allowed pulse
    run_op(8'h14, 8'h00, MAXP + 1, 0); // limit hit in the same compare
    run_op(8'h15, 8'h3C, 1, 0);        // back to normal after clear

    for (int k = 0; k < 16; k++) begin
      nd = ($urandom_range(7, 0) == 0) ? int'($urandom_range(30, 20)) : int'($urandom_range(6, 1));
      run_op(AW'($urandom()), 8'($urandom()), nd, int'($urandom_range(3, 0)));
    end

    summary();
    $finish;
  end
endmodule